// File: doc/BRIEF.md
# Three-Mode Sixteen-Bit Lookup Cell

This block holds sixteen bits of state behind a single four-bit select and returns one bit. A two-bit mode input decides how the state may change. As a fixed function generator the bits never move and the select simply picks one. As a tiny memory, one bit at the selected location is rewritten when a write strobe is asserted. As a shift register the bits travel one place toward the top on each enabled clock, new data entering at the bottom. In that case the select chooses which stage is read out, and the top stage is always presented on a separate cascade pin so several cells can be chained.

Independently of mode, a configuration strobe replaces the whole sixteen-bit contents from a parallel word in one clock. The read path is purely combinational from the select and the stored bits. All state changes happen on the rising clock edge, and an active-low asynchronous reset clears the contents. All pins are plain level signals. There is no flow control: every enabled edge takes effect, so no back-pressure exists.

Top module: `lutcell_top`

## Requirements
- R1: After reset every stored bit reads 0 at all sixteen select values, and the cascade output is 0.
- R2: With `cfg_load` high at a rising edge, the contents become `cfg_data`, with bit i readable at select value i after that edge.
- R3: `dout` combinationally equals the stored bit whose index is the binary value of `sel`, for every select value.
- R4: In fixed-function mode (`mode` = 2'b00) and in the reserved code 2'b11, the contents never change, whatever `wr_en`, `wr_bit`, `sh_en` and `sh_in` do.
- R5: In memory mode (`mode` = 2'b01) with `wr_en` high, the bit at index `sel` takes `wr_bit` at the rising edge, and all other bits keep their values.
- R6: In memory mode with `wr_en` low, all sixteen bits stay unchanged.
- R7: In shift mode (`mode` = 2'b10) with `sh_en` high, bit 0 takes `sh_in` and bit i takes the old bit i-1 for i = 1..15. With `sh_en` low the contents hold.
- R8: `cascade_out` always equals stored bit 15.
- R9: A configuration load takes priority over a memory write or a shift in the same cycle.
- R10: The shift controls have no effect in memory mode, and the write controls have no effect in shift mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears contents |
| mode | input | 2 | 00 fixed function, 01 memory, 10 shift, 11 treated as 00 |
| sel | input | 4 | Read select; write address in memory mode |
| wr_en | input | 1 | Write strobe, memory mode only |
| wr_bit | input | 1 | Data bit written in memory mode |
| sh_en | input | 1 | Shift strobe, shift mode only |
| sh_in | input | 1 | Serial bit entering stage 0 |
| cfg_load | input | 1 | Parallel load of all contents, overrides other updates |
| cfg_data | input | 16 | Parallel load word, bit i goes to stage i |
| dout | output | 1 | Selected stored bit |
| cascade_out | output | 1 | Stored bit 15, for chaining |

## Verification
The situation hardest to reach from the ports is a configuration load that coincides with an active write or shift. Only the load's result may be visible afterwards, so the bench drives all three strobes together in memory and shift modes. The load word is chosen so that it differs from the bit the write or the shift would have produced. Every read-back sweeps all sixteen select values against a bench shadow copy, so a stray write to a neighbouring bit or a shift in the wrong direction shows up at once.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_MEM   = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/lutcell_wr_dec.sv
module lutcell_wr_dec #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  mask
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign mask[i] = enable && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/lutcell_store.sv
module lutcell_store #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DEPTH-1:0] load_word,
  input  logic [DEPTH-1:0] wr_mask,
  input  logic             wr_bit,
  input  logic             shift_act,
  input  logic             shift_bit,
  output logic [DEPTH-1:0] cells
);
  logic [DEPTH-1:0] nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    logic chain_src;
    if (i == 0) begin : g_head
      assign chain_src = shift_bit;
    end else begin : g_body
      assign chain_src = cells[i-1];
    end
    always_comb begin
      if (load)            nxt[i] = load_word[i];
      else if (wr_mask[i]) nxt[i] = wr_bit;
      else if (shift_act)  nxt[i] = chain_src;
      else                 nxt[i] = cells[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= nxt;
  end
endmodule

// File: rtl/lutcell_rd_mux.sv
module lutcell_rd_mux #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NODES = 2 * DEPTH - 1
) (
  input  logic [DEPTH-1:0]  cells,
  input  logic [ADDR_W-1:0] sel,
  output logic              bit_out
);
  logic [NODES-1:0] node;

  for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
    assign node[DEPTH-1+i] = cells[i];
  end
  for (genvar d = 0; d < ADDR_W; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int K = (1 << d) - 1 + j;
      assign node[K] = sel[ADDR_W-1-d] ? node[2*K+2] : node[2*K+1];
    end
  end
  assign bit_out = node[0];
endmodule

// File: rtl/lutcell_top.sv
module lutcell_top #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic              sh_en,
  input  logic              sh_in,
  input  logic              cfg_load,
  input  logic [DEPTH-1:0]  cfg_data,
  output logic              dout,
  output logic              cascade_out
);
  import lutcell_pkg::*;

  cell_mode_e       mode_e;
  logic             mem_wr;
  logic             shift_act;
  logic [DEPTH-1:0] wr_mask;
  logic [DEPTH-1:0] cells;

  assign mode_e    = cell_mode_e'(mode);
  assign mem_wr    = (mode_e == MODE_MEM) && wr_en;
  assign shift_act = (mode_e == MODE_SHIFT) && sh_en;

  lutcell_wr_dec #(.ADDR_W(ADDR_W)) dec_i (
    .enable (mem_wr),
    .addr   (sel),
    .mask   (wr_mask)
  );

  lutcell_store #(.DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .load_word (cfg_data),
    .wr_mask   (wr_mask),
    .wr_bit    (wr_bit),
    .shift_act (shift_act),
    .shift_bit (sh_in),
    .cells     (cells)
  );

  lutcell_rd_mux #(.ADDR_W(ADDR_W)) mux_i (
    .cells   (cells),
    .sel     (sel),
    .bit_out (dout)
  );

  assign cascade_out = cells[DEPTH-1];
endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] sel,
  input logic              wr_en,
  input logic              wr_bit,
  input logic              sh_en,
  input logic              sh_in,
  input logic              cfg_load,
  input logic [DEPTH-1:0]  cfg_data,
  input logic              dout,
  input logic              cascade_out,
  input logic [DEPTH-1:0]  cells
);
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cells == $past(cfg_data)); // R2
  AST_READ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dout == cells[sel]); // R3
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && (mode == 2'b00 || mode == 2'b11)) |=> $stable(cells)); // R4
  AST_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && mode == 2'b01 && wr_en) |=> cells[$past(sel)] == $past(wr_bit)); // R5
  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && mode == 2'b01 && !wr_en) |=> $stable(cells)); // R6
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && mode == 2'b10 && sh_en) |=>
      cells == {$past(cells[DEPTH-2:0]), $past(sh_in)}); // R7
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && mode == 2'b10 && !sh_en) |=> $stable(cells)); // R10
  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out == cells[DEPTH-1]); // R8
endmodule

bind lutcell_top lutcell_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .wr_en(wr_en),
  .wr_bit(wr_bit), .sh_en(sh_en), .sh_in(sh_in), .cfg_load(cfg_load),
  .cfg_data(cfg_data), .dout(dout), .cascade_out(cascade_out), .cells(cells)
);

// File: tb/lutcell_tb_top.sv
module lutcell_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  sel = '0;
  logic        wr_en = 1'b0, wr_bit = 1'b0, sh_en = 1'b0, sh_in = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        dout, cascade_out;
  logic [15:0] exp_v = '0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lutcell_top dut_i (.*);

  task automatic check(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) begin
      sel = 4'(a);
      #1;
      check($sformatf("%s sel=%0d", tag, a), dout, exp_v[a]);
    end
    check({tag, " R8 cascade"}, cascade_out, exp_v[15]);
  endtask

  task automatic step(input logic [1:0] m, input logic [3:0] s, input logic we,
                      input logic wb, input logic se, input logic si,
                      input logic ld, input logic [15:0] cd);
    @(negedge clk);
    mode = m; sel = s; wr_en = we; wr_bit = wb; sh_en = se; sh_in = si;
    cfg_load = ld; cfg_data = cd;
    if (ld)                   exp_v = cd;
    else if (m == 2'b01 && we) exp_v[s] = wb;
    else if (m == 2'b10 && se) exp_v = {exp_v[14:0], si};
    @(posedge clk);
    #1;
    mode = 2'b00; wr_en = 1'b0; sh_en = 1'b0; cfg_load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    sweep("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    step(2'b00, 0, 0, 0, 0, 0, 1, 16'hA5C3);
    sweep("R2 load");
    for (int i = 0; i < 16; i++) begin
      step(2'b01, 4'(i), 0, 0, 0, 0, 1, 16'(1) << i);
      sweep("R3 one-hot");
      step(2'b10, 4'(i), 0, 0, 0, 0, 1, ~(16'(1) << i));
      sweep("R3 one-cold");
    end

    step(2'b00, 0, 0, 0, 0, 0, 1, 16'h3C96);
    for (int i = 0; i < 8; i++) step(2'b00, 4'(i), 1, i[0], 1, 1, 0, 0);
    sweep("R4 mode00");
    for (int i = 0; i < 8; i++) step(2'b11, 4'(i), 1, ~i[0], 1, 0, 0, 0);
    sweep("R4 mode11");

    for (int i = 0; i < 16; i++) begin
      step(2'b01, 4'(i), 1, ~exp_v[i], 0, 0, 0, 0);
      sweep("R5 write");
    end
    for (int i = 0; i < 16; i++) step(2'b01, 4'(i), 0, ~exp_v[i], 0, 0, 0, 0);
    sweep("R6 idle");
    for (int i = 0; i < 6; i++) step(2'b01, 4'(i), 0, 0, 1, i[0], 0, 0);
    sweep("R10 shift in mem mode");

    lf = 16'hACE1;
    for (int i = 0; i < 20; i++) begin
      step(2'b10, 4'(i), 0, 0, 1, lf[0], 0, 0);
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
      sweep("R7 shift");
    end
    for (int i = 0; i < 5; i++) step(2'b10, 4'(i), 0, 0, 0, 1, 0, 0);
    sweep("R7 hold");
    for (int i = 0; i < 16; i++) step(2'b10, 4'(i), 1, ~exp_v[i], 0, 0, 0, 0);
    sweep("R10 write in shift mode");

    step(2'b00, 0, 0, 0, 0, 0, 1, 16'h0000);
    step(2'b01, 4'd5, 1, 1, 0, 0, 1, 16'h0000);
    sweep("R9 load over write");
    step(2'b10, 0, 0, 0, 1, 1, 1, 16'h8000);
    sweep("R9 load over shift");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule